// File: doc/BRIEF.md
# Tributary Justification Buffer Controller

This block serves one tributary lane of a four-lane plesiochronous bit-interleaving multiplexer. Tributary bits arrive serially with a write strobe at the slower nominal rate. They are held in a small elastic store and handed out one bit per read request from the frame assembler, which reads at the faster justified rate. The store therefore tends to drain. The block keeps its own position within the lane's 212-slot share of each frame. For every slot it reports what kind of bit the slot carries, together with the bit value.

Once per frame, at the read of slot 0, a phase comparator looks at how many bits are buffered. If the count is below a threshold, the frame is marked as stuffed. In a stuffed frame the three control slots carry 1, and the opportunity slot sends a dummy 0 without taking a bit from the store. In an unstuffed frame the control slots carry 0, and the opportunity slot carries real data. A sticky error flag records any write into a full store or read from an empty one. Everything runs on one clock, and the writes and reads are qualified by enables.

Top module: `tributary_justifier`

## Requirements
- R1: After synchronous reset, `fill` is 0, and `out_valid`, `stuff_now` and `buf_err` are 0.
- R2: Bits written with `wr_en` leave on data slots and on unstuffed opportunity slots in the order they were written.
- R3: `fill` equals the number of bits accepted minus the number removed, and never exceeds the depth (8). A write and a removal in the same cycle leave it unchanged.
- R4: The read requests step through slots 0..211 and then wrap. `out_kind` is encoded as 0 for overhead (slots 0..2, bit 0), 1 for data, 2 for control (slots 53, 106, 159) and 3 for opportunity (slot 160).
- R5: At the read of slot 0, `stuff_now` is loaded with (fill < 4), using the fill before that cycle. It holds this value until the next read of slot 0.
- R6: Every control slot carries the value of `stuff_now`, so all three are 1 in a stuffed frame and all three are 0 otherwise.
- R7: In a stuffed frame the opportunity slot outputs 0 and removes no bit from the store.
- R8: In an unstuffed frame the opportunity slot outputs the oldest buffered bit and removes it.
- R9: `out_valid` is high in exactly the cycle after each `rd_req`, and the slot's bit and kind are presented in that same cycle.
- R10: A write while the store is full, with no removal in that cycle, is discarded and sets `buf_err`, which stays set until reset.
- R11: A removal requested while the store is empty outputs 0, leaves `fill` at 0 and sets `buf_err`. A write in that same cycle is still stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for one tributary bit |
| wr_bit | input | 1 | Tributary bit value |
| rd_req | input | 1 | Request for this lane's next frame slot |
| out_valid | output | 1 | Slot output is valid (one cycle after `rd_req`) |
| out_bit | output | 1 | Bit for the requested slot |
| out_kind | output | 2 | Slot kind: 0 overhead, 1 data, 2 control, 3 opportunity |
| stuff_now | output | 1 | Stuff decision latched for the current frame |
| fill | output | 4 | Number of buffered bits |
| buf_err | output | 1 | Sticky overflow/underflow flag |

## Verification
The checker assumes that `rd_req` is never asserted during reset, and that reset is held for at least one clock edge so every register starts from a known value. The stimulus drives inputs only on the falling edge and releases reset before the first request. Beyond that, it treats any mix of simultaneous writes and reads as legal. Sweeps at the nominal 32-of-33 write ratio, at full rate and at half rate push the store into steady stuffing, overflow and underflow in turn. Separate prefill runs place the slot-0 fill level exactly at the threshold and one below it.

// File: rtl/tj_pkg.sv
package tj_pkg;

    typedef enum logic [1:0] {
        SK_OVH  = 2'd0,
        SK_DATA = 2'd1,
        SK_CTRL = 2'd2,
        SK_OPP  = 2'd3
    } slot_kind_e;

    typedef struct packed {
        logic       valid;
        logic       bit_v;
        slot_kind_e kind;
    } slot_out_t;

    // Does this slot remove a bit from the elastic store?
    function automatic logic slot_takes_bit(input slot_kind_e kind, input logic stuffed);
        return (kind == SK_DATA) || ((kind == SK_OPP) && !stuffed);
    endfunction

    // Value placed on the line for slots that do not carry stored data
    function automatic logic fixed_slot_bit(input slot_kind_e kind, input logic stuffed);
        logic b;
        case (kind)
            SK_CTRL: b = stuffed;
            default: b = 1'b0;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/tj_slot_tracker.sv
module tj_slot_tracker #(
    parameter int FRAME_SLOTS = 212,
    parameter int GROUP_SLOTS = 53,
    parameter int OVH_SLOTS   = 3,
    parameter int NUM_CTRL    = 3,
    localparam int SLOT_W     = $clog2(FRAME_SLOTS),
    localparam int OPP_SLOT   = NUM_CTRL * GROUP_SLOTS + 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               step,
    output logic               at_start,
    output tj_pkg::slot_kind_e kind
);
    import tj_pkg::*;

    logic [SLOT_W-1:0]   slot_q;
    logic [NUM_CTRL-1:0] ctrl_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q <= '0;
        end else if (step) begin
            if (slot_q == SLOT_W'(FRAME_SLOTS - 1)) slot_q <= '0;
            else                                    slot_q <= slot_q + 1'b1;
        end
    end

    for (genvar k = 0; k < NUM_CTRL; k++) begin : g_ctrl
        assign ctrl_hit[k] = (slot_q == SLOT_W'((k + 1) * GROUP_SLOTS));
    end

    assign at_start = (slot_q == '0);

    always_comb begin
        if (slot_q < SLOT_W'(OVH_SLOTS))       kind = SK_OVH;
        else if (|ctrl_hit)                    kind = SK_CTRL;
        else if (slot_q == SLOT_W'(OPP_SLOT))  kind = SK_OPP;
        else                                   kind = SK_DATA;
    end

endmodule

// File: rtl/tj_elastic_store.sv
module tj_elastic_store #(
    parameter int DEPTH   = 8,
    localparam int PTR_W  = $clog2(DEPTH),
    localparam int CNT_W  = PTR_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic             din,
    input  logic             pop,
    output logic             head,
    output logic [CNT_W-1:0] count,
    output logic             ovf,
    output logic             udf
);
    logic [DEPTH-1:0] mem_q;
    logic [PTR_W-1:0] wp_q, rp_q;
    logic [CNT_W-1:0] cnt_q;
    logic             full, empty, do_pop, do_push;

    assign full    = (cnt_q == CNT_W'(DEPTH));
    assign empty   = (cnt_q == '0);
    assign do_pop  = pop && !empty;
    assign do_push = push && (!full || do_pop);
    assign ovf     = push && full && !do_pop;
    assign udf     = pop && empty;
    assign head    = empty ? 1'b0 : mem_q[rp_q];
    assign count   = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_q <= '0;
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) begin
                mem_q[wp_q] <= din;
                wp_q        <= wp_q + 1'b1;
            end
            if (do_pop) rp_q <= rp_q + 1'b1;
            case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

endmodule

// File: rtl/tj_stuff_decider.sv
module tj_stuff_decider #(
    parameter int CNT_W  = 4,
    parameter int THRESH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             decide,
    input  logic [CNT_W-1:0] level,
    output logic             stuffed
);
    // Phase comparison: a shallow store means the reader is closing on the writer
    always_ff @(posedge clk) begin
        if (rst)         stuffed <= 1'b0;
        else if (decide) stuffed <= (level < CNT_W'(THRESH));
    end

endmodule

// File: rtl/tributary_justifier.sv
module tributary_justifier #(
    parameter int DEPTH       = 8,
    parameter int THRESH      = 4,
    parameter int FRAME_SLOTS = 212,
    parameter int GROUP_SLOTS = 53,
    parameter int OVH_SLOTS   = 3,
    parameter int NUM_CTRL    = 3,
    localparam int CNT_W      = $clog2(DEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             wr_bit,
    input  logic             rd_req,
    output logic             out_valid,
    output logic             out_bit,
    output logic [1:0]       out_kind,
    output logic             stuff_now,
    output logic [CNT_W-1:0] fill,
    output logic             buf_err
);
    import tj_pkg::*;

    slot_kind_e kind;
    logic       at_start, take, head, ovf, udf, err_q;
    slot_out_t  out_q, out_d;

    tj_slot_tracker #(
        .FRAME_SLOTS(FRAME_SLOTS), .GROUP_SLOTS(GROUP_SLOTS),
        .OVH_SLOTS(OVH_SLOTS), .NUM_CTRL(NUM_CTRL)
    ) u_slots (
        .clk(clk), .rst(rst), .step(rd_req), .at_start(at_start), .kind(kind)
    );

    tj_stuff_decider #(.CNT_W(CNT_W), .THRESH(THRESH)) u_decide (
        .clk(clk), .rst(rst), .decide(rd_req && at_start),
        .level(fill), .stuffed(stuff_now)
    );

    assign take = rd_req && slot_takes_bit(kind, stuff_now);

    tj_elastic_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rst(rst), .push(wr_en), .din(wr_bit), .pop(take),
        .head(head), .count(fill), .ovf(ovf), .udf(udf)
    );

    always_comb begin
        out_d.valid = rd_req;
        out_d.kind  = kind;
        out_d.bit_v = slot_takes_bit(kind, stuff_now) ? head : fixed_slot_bit(kind, stuff_now);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
            err_q <= 1'b0;
        end else begin
            out_q.valid <= out_d.valid;
            if (rd_req) begin
                out_q.kind  <= out_d.kind;
                out_q.bit_v <= out_d.bit_v;
            end
            err_q <= err_q | ovf | udf;
        end
    end

    assign out_valid = out_q.valid;
    assign out_bit   = out_q.bit_v;
    assign out_kind  = out_q.kind;
    assign buf_err   = err_q;

endmodule

// File: rtl/tributary_justifier_chk.sv
module tributary_justifier_chk #(
    parameter int DEPTH = 8,
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic             rd_req,
    input logic             out_valid,
    input logic             out_bit,
    input logic [1:0]       out_kind,
    input logic             stuff_now,
    input logic [CNT_W-1:0] fill,
    input logic             buf_err
);
    p_fill_bound_r3: assert property (@(posedge clk) disable iff (rst)
        fill <= CNT_W'(DEPTH));

    p_fill_rise_r3: assert property (@(posedge clk) disable iff (rst)
        (fill > $past(fill)) |-> ($past(wr_en) && (fill == $past(fill) + 1'b1)));

    p_decision_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !$stable(stuff_now) |-> $past(rd_req));

    p_ctrl_flag_r6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_kind == 2'd2) |-> (out_bit == stuff_now));

    p_dummy_zero_r7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_kind == 2'd3 && stuff_now) |-> !out_bit);

    p_valid_follows_req_r9: assert property (@(posedge clk) disable iff (rst)
        out_valid == $past(rd_req));

    p_err_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        buf_err |=> buf_err);

    p_overhead_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_kind == 2'd0) |-> !out_bit);
endmodule

bind tributary_justifier tributary_justifier_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_req(rd_req), .out_valid(out_valid),
    .out_bit(out_bit), .out_kind(out_kind), .stuff_now(stuff_now), .fill(fill),
    .buf_err(buf_err)
);

// File: tb/tributary_justifier_test.sv
`timescale 1ns/1ps
module tributary_justifier_test;
    localparam int DEPTH = 8, THR = 4, SLOTS = 212;

    logic clk = 1'b0, rst = 1'b1, wr_en = 1'b0, wr_bit = 1'b0, rd_req = 1'b0;
    logic out_valid, out_bit, stuff_now, buf_err;
    logic [1:0] out_kind;
    logic [3:0] fill;

    int compared = 0, mismatched = 0;
    bit done = 0;

    // bench model state
    bit q[$];
    int slot = 0;
    bit m_stuff = 0, m_err = 0, m_valid = 0, m_bit = 0;
    int m_kind = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #2.5 clk = ~clk;

    tributary_justifier uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_bit(wr_bit), .rd_req(rd_req),
        .out_valid(out_valid), .out_bit(out_bit), .out_kind(out_kind),
        .stuff_now(stuff_now), .fill(fill), .buf_err(buf_err)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic int kind_of(input int s);
        if (s < 3) return 0;
        if (s == 53 || s == 106 || s == 159) return 2;
        if (s == 160) return 3;
        return 1;
    endfunction

    task automatic model_edge(input bit w, input bit wb, input bit r);
        int cnt = q.size();
        bit popped = 0;
        m_valid = r;
        if (r) begin
            m_kind = kind_of(slot);
            if (slot == 0) m_stuff = (cnt < THR);
            if (m_kind == 0)       m_bit = 0;
            else if (m_kind == 2)  m_bit = m_stuff;
            else if (m_kind == 3 && m_stuff) m_bit = 0;
            else begin
                if (cnt == 0) begin m_bit = 0; m_err = 1; end
                else begin m_bit = q.pop_front(); popped = 1; end
            end
            slot = (slot == SLOTS - 1) ? 0 : slot + 1;
        end
        if (w) begin
            if (cnt == DEPTH && !popped) m_err = 1;
            else q.push_back(wb);
        end
    endtask

    task automatic compare_all();
        check(out_valid == m_valid, "R9 valid", out_valid, m_valid);
        check(fill == q.size(), "R3 fill", fill, q.size());
        check(stuff_now == m_stuff, "R5 stuff", stuff_now, m_stuff);
        check(buf_err == m_err, "R10/R11 err", buf_err, m_err);
        if (m_valid) begin
            check(out_kind == m_kind, "R4 kind", out_kind, m_kind);
            case (m_kind)
                0: check(out_bit == m_bit, "R4 overhead bit", out_bit, m_bit);
                2: check(out_bit == m_bit, "R6 control bit", out_bit, m_bit);
                3: check(out_bit == m_bit, m_stuff ? "R7 dummy bit" : "R8 opportunity data", out_bit, m_bit);
                default: check(out_bit == m_bit, "R2 data order", out_bit, m_bit);
            endcase
        end
    endtask

    task automatic step(input bit w, input bit r);
        wr_en  = w;
        wr_bit = lfsr[0];
        rd_req = r;
        @(posedge clk);
        model_edge(w, lfsr[0], r);
        if (w) lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        @(negedge clk);
        compare_all();
    endtask

    task automatic do_reset();
        rst = 1'b1; wr_en = 0; rd_req = 0;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        q.delete(); slot = 0; m_stuff = 0; m_err = 0; m_valid = 0;
        // R1: reset state
        check(fill == 0, "R1 fill", fill, 0);
        check(out_valid == 0, "R1 valid", out_valid, 0);
        check(stuff_now == 0, "R1 stuff", stuff_now, 0);
        check(buf_err == 0, "R1 err", buf_err, 0);
    endtask

    // mode: 0 nominal 32/33, 1 every slot, 2 every other slot
    task automatic run(input int mode, input int frames);
        for (int s = 0; s < frames * SLOTS; s++) begin
            bit w;
            case (mode)
                0: w = (s % 33) != 32;
                1: w = 1;
                default: w = (s % 2) == 0;
            endcase
            step(0, 1);
            step(w, 0);
            step(0, 0);
            step(0, 0);
        end
    endtask

    task automatic prefill_run(input int n);
        do_reset();
        for (int i = 0; i < n; i++) step(1, 0);
        step(0, 1);
        // R5 threshold boundary: fill 4 does not stuff, fill 3 does
        check(stuff_now == (n < THR), "R5 boundary", stuff_now, n < THR);
        run(0, 2);
    endtask

    initial begin
        @(negedge clk);
        do_reset();
        run(0, 6);               // R2 R4 R5 R6 R7 R8 R9 at nominal ratio
        do_reset();
        run(1, 3);               // R10 overflow at full rate
        check(buf_err == 1, "R10 overflow flagged", buf_err, 1);
        do_reset();
        run(2, 1);               // R11 underflow at half rate
        check(buf_err == 1, "R11 underflow flagged", buf_err, 1);
        prefill_run(THR);
        prefill_run(THR - 1);
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            compared++; mismatched++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule